// File: doc/BRIEF.md
# Debug Trap Controller

This block decides, for every issued instruction, whether a debug trap is taken and for what reason. It owns the instruction-breakpoint enable mask, a set of instruction-breakpoint address registers, an instruction counter with its count-level threshold, and a read-only cause register. Each issue cycle it combines four kinds of request into a single trap decision with one prioritised cause. The requests are counter overflow, an address-match breakpoint, an external data-breakpoint request carrying a comparator number, and the wide and narrow break instructions flagged by decode.

When a trap is taken, the block emits a one-cycle vector-select pulse. With the pulse it gives the values that the surrounding register file saves into the level-specific EPC and EPS pair, the level index that selects that pair, and the new processor status word. Traps, and the break instructions themselves, only take effect while the current interrupt level is below the configured debug level. Otherwise nothing is raised and a break instruction acts as a no-op.

Software reaches the registers through a simple select/write/read port. Reads are combinational. Writes land on the next clock edge.

Top module: `dbg_trap_ctrl`

## Requirements
- R1: Register select codes on `cfg_sel` are: 0 breakpoint enable mask, 1 instruction counter, 2 count level, 3 cause, 4+i breakpoint address i. Unmapped codes read as zero.
- R2: On an issue cycle where `cur_intlvl` is below the count level, the counter is incremented. In all other cycles without a counter write, the counter is unchanged.
- R3: If an increment would produce zero, the counter keeps its old value and a count-overflow request (cause 0x1) is raised. The counter freezes the same way even when the trap itself is gated off.
- R4: A write to the count level keeps only the low 4 bits of the written data.
- R5: Breakpoint i fires when enable bit i is set and its address equals `issue_pc`, giving cause 0x2. The enable mask keeps only its NUM_IBRK low bits.
- R6: Cause bits are 0x1 count overflow, 0x2 address breakpoint, 0x4 data breakpoint with `dbrk_num` in bits 11:8, 0x8 wide break, and 0x10 narrow break. Priority runs count, then address, then data, then wide, then narrow. Only the winning cause is stored, and a single pulse is produced.
- R7: No trap is taken while `cur_intlvl` is greater than or equal to DEBUG_LEVEL. In that state a break instruction has no effect.
- R8: One cycle after a trapping issue, `trap_pulse` is high and `trap_epc` holds the issue PC. `trap_eps` holds the old status word and `trap_lvl` equals DEBUG_LEVEL. `trap_ps_new` is the old word with bits 3:0 (interrupt level) set to DEBUG_LEVEL and bit 4 (exception mode) set. The cause register is loaded on the same edge.
- R9: Writes to the cause register are ignored.
- R10: Synchronous reset clears the enable mask, counter, count level, cause, and all trap outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register value |
| issue_vld | input | 1 | An instruction is about to execute |
| issue_pc | input | ADDR_W | PC of that instruction |
| brk_wide | input | 1 | Instruction is the wide break form |
| brk_narrow | input | 1 | Instruction is the narrow break form |
| dbrk_req | input | 1 | External data-breakpoint hit |
| dbrk_num | input | 4 | Number of the data comparator that hit |
| cur_ps | input | 32 | Current processor status word |
| cur_intlvl | input | 4 | Current interrupt level |
| trap_pulse | output | 1 | Debug vector select pulse |
| trap_lvl | output | 4 | Level index for the EPC/EPS pair |
| trap_epc | output | ADDR_W | Value to save into EPC |
| trap_eps | output | 32 | Value to save into EPS |
| trap_ps_new | output | 32 | Status word to install on entry |

## Verification
The embedded assertions check the following on every cycle: the counter does not drift when idle, freezes at the wrap point, and steps by one when counting. The stored cause is never more than one-hot. No pulse follows an issue at or above the debug level. The saved EPC and EPS match the issue cycle. A write to the cause register leaves it unchanged. The directed scenarios are the only place where the rest is shown: the value of each cause and the data-comparator field, the priority between simultaneous requests, the masking of the enable and level registers, and the breakpoint enable and address interplay.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

    localparam int SEL_W      = 3;
    localparam int LVL_W      = 4;
    localparam int EXCM_BIT   = 4;

    localparam logic [SEL_W-1:0] SEL_IBEN  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ICNT  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ICLVL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CAUSE = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IBA0  = 3'd4;

    // Stored cause word, bit 0 at the right.
    typedef struct packed {
        logic [3:0] dnum;
        logic [2:0] pad;
        logic       bn;
        logic       bi;
        logic       db;
        logic       ib;
        logic       ic;
    } cause_t;

    // Raw requests for the current issue cycle.
    typedef struct packed {
        logic       ic;
        logic       ib;
        logic       db;
        logic       bi;
        logic       bn;
        logic [3:0] dnum;
    } req_t;

    function automatic logic any_req(req_t r);
        return r.ic | r.ib | r.db | r.bi | r.bn;
    endfunction

    // Keep only the highest-priority request.
    function automatic cause_t pick_cause(req_t r);
        cause_t c;
        c = '0;
        if (r.ic) begin
            c.ic = 1'b1;
        end else if (r.ib) begin
            c.ib = 1'b1;
        end else if (r.db) begin
            c.db   = 1'b1;
            c.dnum = r.dnum;
        end else if (r.bi) begin
            c.bi = 1'b1;
        end else if (r.bn) begin
            c.bn = 1'b1;
        end
        return c;
    endfunction

    // Status word on entry: level field replaced, exception mode raised.
    function automatic logic [31:0] ps_enter(logic [31:0] ps, logic [LVL_W-1:0] lvl);
        logic [31:0] p;
        p = ps;
        p[LVL_W-1:0] = lvl;
        p[EXCM_BIT]  = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/dbg_icount_unit.sv
module dbg_icount_unit
    import dbg_trap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cnt,
    input  logic             wr_lvl,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [LVL_W-1:0] lvl_wdata,
    input  logic             step,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic [CNT_W-1:0] cnt_q,
    output logic [LVL_W-1:0] lvl_q,
    output logic             ic_req
);

    logic             count_en;
    logic [CNT_W-1:0] cnt_inc;
    logic             wrap;

    assign count_en = step && (cur_lvl < lvl_q);
    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign wrap     = (cnt_inc == '0);
    assign ic_req   = count_en && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= '0;
        end else begin
            if (wr_lvl) begin
                lvl_q <= lvl_wdata;
            end
            if (wr_cnt) begin
                cnt_q <= cnt_wdata;
            end else if (count_en && !wrap) begin
                cnt_q <= cnt_inc;
            end
        end
    end

    AST_ICNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !wr_cnt) |=> $stable(cnt_q)); // R2
    AST_ICNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_en && !wrap && !wr_cnt) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
    AST_ICNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (count_en && wrap && !wr_cnt) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/dbg_ibreak_match.sv
module dbg_ibreak_match
    import dbg_trap_pkg::*;
#(
    parameter int NUM_IBRK = 2,
    parameter int ADDR_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [NUM_IBRK-1:0]            wr_addr,
    input  logic [NUM_IBRK-1:0]            en_wdata,
    input  logic [ADDR_W-1:0]              addr_wdata,
    input  logic [ADDR_W-1:0]              pc,
    output logic [NUM_IBRK-1:0]            en_q,
    output logic [NUM_IBRK-1:0][ADDR_W-1:0] addr_q,
    output logic                           ib_req
);

    logic [NUM_IBRK-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= en_wdata;
        end
    end

    for (genvar i = 0; i < NUM_IBRK; i++) begin : g_bp
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[i] <= '0;
            end else if (wr_addr[i]) begin
                addr_q[i] <= addr_wdata;
            end
        end
        assign hit[i] = en_q[i] && (addr_q[i] == pc);
    end

    assign ib_req = |hit;

    AST_IB_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !ib_req); // R5

endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
    import dbg_trap_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DEBUG_LEVEL = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_vld,
    input  logic [ADDR_W-1:0] pc,
    input  logic [31:0]       cur_ps,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  req_t              req,
    output cause_t            cause_q,
    output logic              trap_pulse,
    output logic [ADDR_W-1:0] trap_epc,
    output logic [31:0]       trap_eps,
    output logic [31:0]       trap_ps_new
);

    localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DEBUG_LEVEL);

    logic   gate_open;
    logic   take;
    cause_t win;

    assign gate_open = (cur_lvl < DBG_LVL);
    assign take      = issue_vld && gate_open && any_req(req);
    assign win       = pick_cause(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q     <= '0;
            trap_pulse  <= 1'b0;
            trap_epc    <= '0;
            trap_eps    <= '0;
            trap_ps_new <= '0;
        end else begin
            trap_pulse <= take;
            if (take) begin
                cause_q     <= win;
                trap_epc    <= pc;
                trap_eps    <= cur_ps;
                trap_ps_new <= ps_enter(cur_ps, DBG_LVL);
            end
        end
    end

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !gate_open) |=> !trap_pulse); // R7
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cause_q.bn, cause_q.bi, cause_q.db, cause_q.ib, cause_q.ic})); // R6
    AST_EPC_SAVE: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && take) |=> (trap_epc == $past(pc))); // R8
    AST_EPS_SAVE: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && take) |=> (trap_eps == $past(cur_ps))); // R8

endmodule

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl
    import dbg_trap_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 32,
    parameter int NUM_IBRK    = 2,
    parameter int DEBUG_LEVEL = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              issue_vld,
    input  logic [ADDR_W-1:0] issue_pc,
    input  logic              brk_wide,
    input  logic              brk_narrow,
    input  logic              dbrk_req,
    input  logic [3:0]        dbrk_num,
    input  logic [31:0]       cur_ps,
    input  logic [3:0]        cur_intlvl,
    output logic              trap_pulse,
    output logic [3:0]        trap_lvl,
    output logic [ADDR_W-1:0] trap_epc,
    output logic [31:0]       trap_eps,
    output logic [31:0]       trap_ps_new
);

    logic                            wr_iben, wr_icnt, wr_iclvl;
    logic [NUM_IBRK-1:0]             wr_iba;
    logic [CNT_W-1:0]                icnt_q;
    logic [LVL_W-1:0]                iclvl_q;
    logic                            ic_req;
    logic [NUM_IBRK-1:0]             iben_q;
    logic [NUM_IBRK-1:0][ADDR_W-1:0] iba_q;
    logic                            ib_req;
    req_t                            req;
    cause_t                          cause_q;

    assign wr_iben  = cfg_we && (cfg_sel == SEL_IBEN);
    assign wr_icnt  = cfg_we && (cfg_sel == SEL_ICNT);
    assign wr_iclvl = cfg_we && (cfg_sel == SEL_ICLVL);

    for (genvar i = 0; i < NUM_IBRK; i++) begin : g_wdec
        assign wr_iba[i] = cfg_we && (cfg_sel == SEL_IBA0 + SEL_W'(i));
    end

    dbg_icount_unit #(.CNT_W(CNT_W)) u_icnt (
        .clk       (clk),
        .rst       (rst),
        .wr_cnt    (wr_icnt),
        .wr_lvl    (wr_iclvl),
        .cnt_wdata (cfg_wdata[CNT_W-1:0]),
        .lvl_wdata (cfg_wdata[LVL_W-1:0]),
        .step      (issue_vld),
        .cur_lvl   (cur_intlvl),
        .cnt_q     (icnt_q),
        .lvl_q     (iclvl_q),
        .ic_req    (ic_req)
    );

    dbg_ibreak_match #(.NUM_IBRK(NUM_IBRK), .ADDR_W(ADDR_W)) u_ibrk (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_iben),
        .wr_addr    (wr_iba),
        .en_wdata   (cfg_wdata[NUM_IBRK-1:0]),
        .addr_wdata (cfg_wdata[ADDR_W-1:0]),
        .pc         (issue_pc),
        .en_q       (iben_q),
        .addr_q     (iba_q),
        .ib_req     (ib_req)
    );

    always_comb begin
        req      = '0;
        req.ic   = ic_req;
        req.ib   = ib_req;
        req.db   = dbrk_req;
        req.bi   = brk_wide;
        req.bn   = brk_narrow;
        req.dnum = dbrk_num;
    end

    dbg_cause_arb #(.ADDR_W(ADDR_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .issue_vld   (issue_vld),
        .pc          (issue_pc),
        .cur_ps      (cur_ps),
        .cur_lvl     (cur_intlvl),
        .req         (req),
        .cause_q     (cause_q),
        .trap_pulse  (trap_pulse),
        .trap_epc    (trap_epc),
        .trap_eps    (trap_eps),
        .trap_ps_new (trap_ps_new)
    );

    assign trap_lvl = LVL_W'(DEBUG_LEVEL);

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_IBEN:  cfg_rdata = 32'(iben_q);
            SEL_ICNT:  cfg_rdata = 32'(icnt_q);
            SEL_ICLVL: cfg_rdata = 32'(iclvl_q);
            SEL_CAUSE: cfg_rdata = 32'(cause_q);
            default: begin
                for (int i = 0; i < NUM_IBRK; i++) begin
                    if (cfg_sel == SEL_IBA0 + SEL_W'(i)) begin
                        cfg_rdata = 32'(iba_q[i]);
                    end
                end
            end
        endcase
    end

    AST_CAUSE_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_sel == SEL_CAUSE) && !issue_vld) |=> $stable(cause_q)); // R9

endmodule

// File: tb/sim_dbg_trap_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_trap_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        issue_vld = 1'b0;
    logic [31:0] issue_pc = '0;
    logic        brk_wide = 1'b0;
    logic        brk_narrow = 1'b0;
    logic        dbrk_req = 1'b0;
    logic [3:0]  dbrk_num = '0;
    logic [31:0] cur_ps = 32'h0004_0025;
    logic [3:0]  cur_intlvl = 4'd5;
    logic        trap_pulse;
    logic [3:0]  trap_lvl;
    logic [31:0] trap_epc, trap_eps, trap_ps_new;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dbg_trap_ctrl u0 (.*);

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        cfg_sel = sel;
        #1;
        check(cfg_rdata, exp, tag);
    endtask

    function automatic logic [31:0] exp_ps(input logic [31:0] ps);
        return (ps & ~32'h1F) | 32'h10 | 32'd6;
    endfunction

    // Issue one instruction; check pulse, saved values and the cause register.
    task automatic issue(input logic [31:0] pc, input logic w, input logic n,
                         input logic db, input logic [3:0] dn,
                         input logic exp_trap, input logic [31:0] exp_cause, input string tag);
        @(negedge clk);
        issue_vld = 1'b1; issue_pc = pc; brk_wide = w; brk_narrow = n;
        dbrk_req = db; dbrk_num = dn;
        @(negedge clk);
        issue_vld = 1'b0; brk_wide = 1'b0; brk_narrow = 1'b0; dbrk_req = 1'b0;
        check({31'd0, trap_pulse}, {31'd0, exp_trap}, {tag, " pulse"});
        if (exp_trap) begin
            check(trap_epc, pc, {tag, " R8 epc"});
            check(trap_eps, cur_ps, {tag, " R8 eps"});
            check(trap_ps_new, exp_ps(cur_ps), {tag, " R8 new ps"});
            check({28'd0, trap_lvl}, 32'd6, {tag, " R8 level"});
        end
        rd(3'd3, exp_cause, {tag, " cause"});
    endtask

    task automatic t_reset;
        check({31'd0, trap_pulse}, 32'd0, "R10 pulse");
        rd(3'd0, 32'd0, "R10 enable");
        rd(3'd1, 32'd0, "R10 counter");
        rd(3'd2, 32'd0, "R10 level");
        rd(3'd3, 32'd0, "R10 cause");
        rd(3'd7, 32'd0, "R1 unmapped");
    endtask

    task automatic t_masks;
        wr(3'd2, 32'h37);
        rd(3'd2, 32'h7, "R4 level mask");
        wr(3'd2, 32'h0);
        wr(3'd0, 32'hFF);
        rd(3'd0, 32'h3, "R5 enable mask");
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0000_2000);
        wr(3'd5, 32'h0000_3000);
        rd(3'd4, 32'h0000_2000, "R1 bp0 addr");
        rd(3'd5, 32'h0000_3000, "R1 bp1 addr");
    endtask

    task automatic t_breaks;
        issue(32'h100, 1, 0, 0, 0, 1, 32'h8, "R6 wide");
        issue(32'h104, 0, 1, 0, 0, 1, 32'h10, "R6 narrow");
        issue(32'h108, 0, 0, 1, 4'd1, 1, 32'h104, "R6 data bp1");
        cur_intlvl = 4'd6;
        issue(32'h10C, 1, 0, 0, 0, 0, 32'h104, "R7 wide gated");
        issue(32'h110, 0, 1, 1, 4'd2, 0, 32'h104, "R7 narrow gated");
        cur_intlvl = 4'd5;
    endtask

    task automatic t_ibreak;
        issue(32'h2000, 0, 0, 0, 0, 0, 32'h104, "R5 disabled");
        wr(3'd0, 32'h1);
        issue(32'h2000, 0, 0, 0, 0, 1, 32'h2, "R5 bp0 hit");
        issue(32'h3000, 0, 0, 0, 0, 0, 32'h2, "R5 bp1 off");
        issue(32'h2004, 0, 0, 0, 0, 0, 32'h2, "R5 bp0 miss");
        wr(3'd0, 32'h2);
        issue(32'h3000, 0, 0, 0, 0, 1, 32'h2, "R5 bp1 hit");
        issue(32'h4000, 0, 1, 0, 0, 1, 32'h10, "R6 narrow after");
        issue(32'h2000, 0, 0, 0, 0, 0, 32'h10, "R5 bp0 off");
        wr(3'd0, 32'h3);
        issue(32'h2000, 1, 0, 1, 4'd3, 1, 32'h2, "R6 addr over data and wide");
        issue(32'h4444, 1, 1, 1, 4'd5, 1, 32'h504, "R6 data over breaks");
        issue(32'h4448, 1, 1, 0, 0, 1, 32'h8, "R6 wide over narrow");
        cur_intlvl = 4'd7;
        issue(32'h3000, 0, 0, 0, 0, 0, 32'h8, "R7 bp gated");
        cur_intlvl = 4'd5;
    endtask

    task automatic t_icount;
        cur_intlvl = 4'd0;
        issue(32'h500, 0, 0, 0, 0, 0, 32'h8, "R2 level zero no count");
        rd(3'd1, 32'h0, "R2 counter held");
        wr(3'd2, 32'h1);
        wr(3'd1, 32'hFFFF_FFFD);
        issue(32'h504, 0, 0, 0, 0, 0, 32'h8, "R2 step");
        rd(3'd1, 32'hFFFF_FFFE, "R2 counter +1");
        repeat (3) @(negedge clk);
        rd(3'd1, 32'hFFFF_FFFE, "R2 idle hold");
        issue(32'h508, 0, 0, 0, 0, 0, 32'h8, "R2 step2");
        rd(3'd1, 32'hFFFF_FFFF, "R2 counter max");
        issue(32'h50C, 0, 0, 0, 0, 1, 32'h1, "R3 overflow");
        rd(3'd1, 32'hFFFF_FFFF, "R3 frozen");
        issue(32'h2000, 1, 0, 1, 4'd2, 1, 32'h1, "R6 count wins");
        cur_intlvl = 4'd1;
        issue(32'h510, 0, 0, 0, 0, 0, 32'h1, "R2 level blocks");
        wr(3'd1, 32'h5);
        issue(32'h514, 0, 0, 0, 0, 0, 32'h1, "R2 blocked step");
        rd(3'd1, 32'h5, "R2 blocked value");
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'h8);
        cur_intlvl = 4'd7;
        issue(32'h518, 0, 0, 0, 0, 0, 32'h1, "R7 overflow gated");
        rd(3'd1, 32'hFFFF_FFFF, "R3 frozen while gated");
        wr(3'd2, 32'h0);
        cur_intlvl = 4'd5;
    endtask

    task automatic t_cause_wr;
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h1, "R9 cause write ignored");
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, 32'h1, "R9 cause write ignored ones");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_masks;
        t_breaks;
        t_ibreak;
        t_icount;
        t_cause_wr;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule